// File: doc/BRIEF.md
# Dual-Width Character Column Timing Generator

This block produces the horizontal column timing for a character video display that can show either 32 or 64 characters per line. It runs on a single master clock. The divided dot clock is a one-cycle enable rather than a real clock. A single mode input selects the line width, and that choice sets two things at once: how often the dot enable fires, and which counter bit ends the active region of the line.

Each line starts with a periodic line-start pulse. That pulse releases the column-clear latch, and the column counter then advances once per dot. When the counter reaches the last dot of the line, the block issues a one-cycle end-of-line strobe, and the latch sets again. The latch holds the counter at zero and keeps the display blanked through the guard band until the next line-start pulse arrives. The mode input is only taken in while the line is blanked, so a line always has a single width from start to end.

Top module: `col_timing_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `col_blank` is 1, `col_count` is 0, and `dot_en` and `eol_strobe` are both 0.
- R2: With `wide_mode` = 1 (64 columns), `dot_en` is 1 in every master-clock cycle of the active line, for exactly 512 dots (64 characters of 8 dots).
- R3: With `wide_mode` = 0 (32 columns), `dot_en` is 1 every second cycle, starting in the first active cycle, for exactly 256 dots (32 characters of 8 dots).
- R4: `col_count` starts from 0 in the first active cycle and rises by one after each dot. It never counts past the line length: 512 in wide mode, 256 in narrow mode.
- R5: `eol_strobe` is 1 for exactly one cycle. That cycle is the first one in which `col_count` has reached the line length, which is the cycle in which count bit 9 (wide) or bit 8 (narrow) first rises.
- R6: `col_blank` goes to 1 in the cycle after `eol_strobe`. While it is 1, `dot_en` stays 0, and from the following cycle on `col_count` is held at 0.
- R7: When `line_start` is sampled high while `col_blank` is 1, `col_blank` drops to 0 at that clock edge and counting begins at once.
- R8: `wide_mode` is sampled only while `col_blank` is 1. A change during the active line has no effect on that line, and it takes effect from the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (12 MHz in the target system) |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1 selects 64 columns, 0 selects 32 columns |
| line_start | input | 1 | Periodic line-start pulse that releases the column clear |
| dot_en | output | 1 | One-cycle dot-clock enable |
| col_count | output | 10 | Dots counted since the line started |
| eol_strobe | output | 1 | One-cycle end-of-active-line strobe |
| col_blank | output | 1 | Column clear / blank: counter held at zero, video blanked |

## Verification
The embedded properties assume two things about the inputs. First, each line-start pulse arrives after the previous line's end-of-line strobe, because the line period is longer than the widest active region. Second, `wide_mode` may change at any cycle, so the block itself has to keep the latched mode stable within a line. The stimulus follows this by issuing a six-cycle line-start pulse once every 3072 cycles, which leaves a long guard band after even a 512-cycle wide line. It also flips `wide_mode` deliberately in the middle of a line to show that the line is not affected. One scenario asserts reset while a line is active, so the return to the blanked, zeroed state is checked from mid-count and not only from power-up.

// File: rtl/col_timing_pkg.sv
package col_timing_pkg;

   typedef enum logic {
      COLS_NARROW = 1'b0,
      COLS_WIDE   = 1'b1
   } col_mode_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/col_dot_divider.sv
module col_dot_divider
   import col_timing_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      hold,
   input  col_mode_e mode,
   output logic      dot_tick
);

   logic half_q;

   // divide-by-2 phase, parked at zero while the line is cleared
   always_ff @(posedge clk) begin
      if (rst || hold)
         half_q <= 1'b0;
      else
         half_q <= ~half_q;
   end

   always_comb begin
      dot_tick = !hold && ((mode == COLS_WIDE) || !half_q);
   end

   AST_NARROW_GAP: assert property (@(posedge clk) disable iff (rst)
      (dot_tick && mode == COLS_NARROW) |=> !dot_tick); // R3

endmodule

// File: rtl/col_counter.sv
module col_counter #(
   parameter int CNT_W = 10,
   parameter int TAP_W = 9,
   parameter int TAP_N = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             step,
   input  logic             wide,
   output logic [CNT_W-1:0] count,
   output logic             tap_hit
);

   logic [CNT_W-1:0] carry;

   assign carry[0] = step;

   // cascade of toggle stages, each halving the rate of the one below
   for (genvar i = 0; i < CNT_W; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst || clr)
            count[i] <= 1'b0;
         else if (carry[i])
            count[i] <= ~count[i];
      end
      if (i < CNT_W - 1) begin : g_carry
         assign carry[i+1] = carry[i] & count[i];
      end
   end

   assign tap_hit = wide ? count[TAP_W] : count[TAP_N];

   AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
      clr |=> (count == '0)); // R6

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (step && !clr) |=> (count == $past(count) + 1'b1)); // R4

endmodule

// File: rtl/col_line_gate.sv
module col_line_gate (
   input  logic clk,
   input  logic rst,
   input  logic set_eol,
   input  logic release_line,
   output logic clr_q
);

   // set-dominant latch: the end-of-line strobe sets, line start releases
   always_ff @(posedge clk) begin
      if (rst || set_eol)
         clr_q <= 1'b1;
      else if (release_line)
         clr_q <= 1'b0;
   end

   AST_BLANK_AFTER_EOL: assert property (@(posedge clk) disable iff (rst)
      set_eol |=> clr_q); // R6

   AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (clr_q && release_line && !set_eol) |=> !clr_q); // R7

endmodule

// File: rtl/col_timing_gen.sv
module col_timing_gen
   import col_timing_pkg::*;
#(
   parameter int DOTS_PER_CHAR = 8,
   parameter int WIDE_COLS     = 64,
   parameter int NARROW_COLS   = 32,
   localparam int WIDE_DOTS    = WIDE_COLS * DOTS_PER_CHAR,
   localparam int NARROW_DOTS  = NARROW_COLS * DOTS_PER_CHAR,
   localparam int TAP_W        = $clog2(WIDE_DOTS),
   localparam int TAP_N        = $clog2(NARROW_DOTS),
   localparam int CNT_W        = TAP_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wide_mode,
   input  logic             line_start,
   output logic             dot_en,
   output logic [CNT_W-1:0] col_count,
   output logic             eol_strobe,
   output logic             col_blank
);

   initial begin
      if (!is_pow2(DOTS_PER_CHAR) || !is_pow2(WIDE_COLS) || !is_pow2(NARROW_COLS))
         $fatal(1, "column and dot counts must be powers of two");
      if (NARROW_COLS >= WIDE_COLS)
         $fatal(1, "narrow width must be below wide width");
   end

   col_mode_e mode_q;
   logic      clr_q;
   logic      dot_tick;
   logic      tap_hit;

   // width is latched only while the line is cleared
   always_ff @(posedge clk) begin
      if (rst)
         mode_q <= COLS_WIDE;
      else if (clr_q)
         mode_q <= col_mode_e'(wide_mode);
   end

   col_dot_divider u_div (
      .clk      (clk),
      .rst      (rst),
      .hold     (clr_q),
      .mode     (mode_q),
      .dot_tick (dot_tick)
   );

   col_counter #(
      .CNT_W (CNT_W),
      .TAP_W (TAP_W),
      .TAP_N (TAP_N)
   ) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr_q),
      .step    (dot_en),
      .wide    (mode_q == COLS_WIDE),
      .count   (col_count),
      .tap_hit (tap_hit)
   );

   col_line_gate u_gate (
      .clk          (clk),
      .rst          (rst),
      .set_eol      (eol_strobe),
      .release_line (line_start),
      .clr_q        (clr_q)
   );

   assign dot_en     = dot_tick && !tap_hit;
   assign eol_strobe = tap_hit && !clr_q;
   assign col_blank  = clr_q;

   AST_EOL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      eol_strobe |=> !eol_strobe); // R5

   AST_NO_DOT_BLANK: assert property (@(posedge clk) disable iff (rst)
      col_blank |-> !dot_en); // R6

   AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
      !col_blank |=> $stable(mode_q)); // R8

   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
      !col_blank |-> (col_count <= CNT_W'(WIDE_DOTS))); // R4

endmodule

// File: tb/col_timing_gen_tb.sv
module col_timing_gen_tb;

   localparam int LINE_CYC  = 3072;
   localparam int START_CYC = 6;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wide_mode = 1'b1;
   logic       line_start = 1'b0;
   logic       dot_en;
   logic [9:0] col_count;
   logic       eol_strobe;
   logic       col_blank;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   col_timing_gen u_dut (
      .clk        (clk),
      .rst        (rst),
      .wide_mode  (wide_mode),
      .line_start (line_start),
      .dot_en     (dot_en),
      .col_count  (col_count),
      .eol_strobe (eol_strobe),
      .col_blank  (col_blank)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      chk(col_blank == 1'b1, req, col_blank, 1);
      chk(col_count == 10'd0, req, col_count, 0);
      chk(dot_en == 1'b0, req, dot_en, 0);
      chk(eol_strobe == 1'b0, req, eol_strobe, 0);
   endtask

   task automatic test_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check_idle("R1 in reset");
      rst = 1'b0;
      @(negedge clk);
      check_idle("R1 after reset");
   endtask

   // one full line; flip_mid toggles wide_mode part way through the line
   task automatic run_line(input bit wide, input bit flip_mid);
      int exp_dots = wide ? 512 : 256;
      int exp_eol  = wide ? 513 : 512;
      int dots = 0, eols = 0, eol_at = -1;
      int pat_err = 0, cnt_err = 0, blank_err = 0;
      wide_mode = wide;
      for (int i = 0; i < LINE_CYC; i++) begin
         @(negedge clk);
         if (i == 0)
            chk(col_blank == 1'b1, "R6 blank before line start", col_blank, 1);
         if (dot_en) dots++;
         if (eol_strobe) begin
            eols++;
            if (eol_at < 0) eol_at = i;
         end
         if (i >= 1 && i < exp_eol) begin
            if (dot_en != (wide ? 1'b1 : 1'(i % 2))) pat_err++;
            if (int'(col_count) != (wide ? i - 1 : i / 2)) cnt_err++;
            if (col_blank) blank_err++;
         end
         if (eol_at >= 0 && i > eol_at) begin
            if (!col_blank || dot_en) blank_err++;
            if (i > eol_at + 1 && col_count != 10'd0) cnt_err++;
         end
         if (i == exp_eol)
            chk(int'(col_count) == exp_dots, "R4 count at end of line", col_count, exp_dots);
         line_start = (i < START_CYC);
         if (flip_mid && i == 100) wide_mode = ~wide;
      end
      chk(dots == exp_dots, wide ? "R2 wide dot total" : "R3 narrow dot total", dots, exp_dots);
      chk(pat_err == 0, wide ? "R2 wide dot cadence" : "R3 narrow dot cadence", pat_err, 0);
      chk(cnt_err == 0, "R4 count sequence", cnt_err, 0);
      chk(eols == 1, "R5 single strobe", eols, 1);
      chk(eol_at == exp_eol, "R5 strobe cycle", eol_at, exp_eol);
      chk(blank_err == 0, "R6 R7 blank window", blank_err, 0);
      if (flip_mid)
         chk(dots == exp_dots, "R8 mid-line mode change ignored", dots, exp_dots);
   endtask

   task automatic test_mid_reset();
      wide_mode = 1'b1;
      @(negedge clk);
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      chk(col_blank == 1'b0, "R7 release on line start", col_blank, 0);
      repeat (40) @(negedge clk);
      chk(col_count != 10'd0, "R4 counting before reset", col_count, 40);
      rst = 1'b1;
      @(negedge clk);
      check_idle("R1 reset mid-line");
      rst = 1'b0;
      repeat (LINE_CYC) @(negedge clk);
      check_idle("R1 stays blank without line start");
   endtask

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      test_reset();
      run_line(1'b1, 1'b0);
      run_line(1'b0, 1'b0);
      run_line(1'b1, 1'b1);
      run_line(1'b0, 1'b0);
      run_line(1'b0, 1'b1);
      run_line(1'b1, 1'b0);
      test_mid_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule